// File: doc/BRIEF.md
# Descriptor Ring Fetch Manager

This block sits between a host that places command descriptors in a ring in memory and a downstream parser that consumes them. The host programs the ring (base word address, size in descriptors, descriptor length, stride, and whether each descriptor carries one extra token-pointer word). It then announces new work by adding to a prepared count. The block keeps its own processed count and a ring pointer. Whenever enough descriptors are pending and the local descriptor FIFO has room for a whole block, it issues one DMA read. It streams the returned words into the FIFO, where the parser pops them.

A block never crosses the end of the ring: it is cut at the wrap point and the next block starts again at the ring base. Only one DMA read is in flight at a time. The processed count and the ring pointer move when the last word of the response arrives.

Register map (write port and a separate combinational read port, 3-bit address):

| Address | Contents |
|---|---|
| 0 | Ring base word address. |
| 1 | Ring size in descriptors, bits [15:0]. |
| 2 | Descriptor length in words [7:0], stride in words [23:16], extra-token flag [30]. |
| 3 | Block size limit [15:0] and pending threshold [31:16]. |
| 4 | Prepared count. |
| 5 | Processed count. |
| 6 | Status. |
| 7 | Ring pointer, read only. |

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset every register reads zero, no DMA request is raised and the FIFO presents no descriptor word.
- R2: A write to address 4 with bit 31 clear adds wdata[15:0] to the prepared count, and address 4 reads it back.
- R3: A write to address 4 or address 5 with bit 31 set clears the prepared count, the processed count and the ring pointer (address 7).
- R4: A prepared-count write that would make pending (prepared minus processed) exceed the ring size is dropped and sets status bit 0. Pending equal to the ring size is accepted. Status bit 1 sets on each completed block. Writing ones to status bits [4:0] clears them.
- R5: While address 3 holds zero, no DMA request is raised.
- R6: A request is raised only when pending is at least the threshold (address 3 bits [31:16]).
- R7: The block holds n descriptors, where n is the smallest of four limits: the block size limit, the FIFO depth divided by the words per descriptor minus one, the pending count, and the descriptors left before the end of the ring. Words per descriptor is the length plus one when the extra-token flag is set.
- R8: The request address is base + pointer × stride. The request length is (n−1) × stride + words per descriptor. No request is raised if the stride is below the words per descriptor.
- R9: The pointer advances by n after each block and returns to zero on reaching the ring size. A block that would pass the ring end is cut there.
- R10: Of each stride of response words only the first (words per descriptor) enter the FIFO, in arrival order. Gap words are discarded.
- R11: A request waits until the FIFO's free words are at least n × words per descriptor.
- R12: A request holds its address and length until accepted. No second request appears while a response is in progress. The processed count grows by n on the last response word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| dma_req_valid | output | 1 | DMA read request valid |
| dma_req_ready | input | 1 | DMA read request accepted |
| dma_req_addr | output | 32 | Word address of the block |
| dma_req_len | output | 16 | Block length in words |
| dma_rsp_valid | input | 1 | Response word valid |
| dma_rsp_data | input | DATA_W | Response word |
| desc_valid | output | 1 | FIFO holds a descriptor word |
| desc_ready | input | 1 | Parser pops the word |
| desc_data | output | DATA_W | Descriptor word at the FIFO head |

## Verification
The bench keeps FIFO_DEPTH at 16 and DATA_W at 32, so the FIFO-derived block cap takes the values 15, 7, 4 and 3 as the descriptor grows from one to four words. A sweep over descriptor lengths 1 to 3, with and without the token word, strides equal to or one above the descriptor, block limits 1 to 5, ring sizes 5 to 7 and thresholds 1 to 2 reaches every limit of the block-size minimum. In this sweep both the threshold stall and the wrap split happen within a few blocks. The DMA responder returns each word's own address as data, so every kept and discarded word can be predicted from arithmetic alone.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  localparam int REG_W = 32;
  localparam int CNT_W = 16;

  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_RING = 3'd1;
  localparam logic [2:0] RA_DESC = 3'd2;
  localparam logic [2:0] RA_CFG  = 3'd3;
  localparam logic [2:0] RA_PREP = 3'd4;
  localparam logic [2:0] RA_PROC = 3'd5;
  localparam logic [2:0] RA_STAT = 3'd6;

  typedef enum logic [1:0] {FS_IDLE, FS_REQ, FS_RESP} fetch_state_e;

  // words each descriptor puts into the FIFO
  function automatic logic [8:0] desc_words(logic [7:0] dlen, logic tok);
    return {1'b0, dlen} + {8'd0, tok};
  endfunction

  // largest block the FIFO can hold, one descriptor kept in reserve
  function automatic logic [CNT_W-1:0] max_block(int unsigned depth, logic [8:0] dw);
    int unsigned per;
    if (dw == '0) return '0;
    per = depth / 32'(dw);
    if (per == 0) return '0;
    return CNT_W'(per - 1);
  endfunction

  function automatic logic [CNT_W-1:0] min2(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [CNT_W-1:0] block_count(logic [CNT_W-1:0] lim, logic [CNT_W-1:0] cap,
                                                   logic [CNT_W-1:0] pend, logic [CNT_W-1:0] room);
    return min2(min2(lim, cap), min2(pend, room));
  endfunction

  function automatic logic [15:0] dma_length(logic [CNT_W-1:0] n, logic [7:0] stride, logic [8:0] dw);
    return 16'(32'(n - 1'b1) * 32'(stride) + 32'(dw));
  endfunction

  function automatic logic [REG_W-1:0] fetch_addr(logic [REG_W-1:0] base, logic [CNT_W-1:0] ptr,
                                                  logic [7:0] stride);
    return base + 32'(ptr) * 32'(stride);
  endfunction

  function automatic logic [CNT_W-1:0] next_ptr(logic [CNT_W-1:0] ptr, logic [CNT_W-1:0] n,
                                                logic [CNT_W-1:0] ring);
    logic [CNT_W:0] s;
    s = {1'b0, ptr} + {1'b0, n};
    return (s >= {1'b0, ring}) ? '0 : s[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/rfm_fifo.sv
module rfm_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (cnt_q != '0);
  assign pop       = out_valid && pop_ready;
  assign out_data  = mem[rd_q];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  // R11: reserved space means a push never meets a full FIFO
  a_r11_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < CW'(DEPTH));
endmodule

// File: rtl/rfm_regs.sv
module rfm_regs
  import rfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [2:0]       raddr,
  output logic [REG_W-1:0] rdata,
  input  logic             done,
  input  logic [CNT_W-1:0] done_n,
  output logic [REG_W-1:0] ring_base,
  output logic [CNT_W-1:0] ring_size,
  output logic [7:0]       dlen,
  output logic [7:0]       stride,
  output logic             tok,
  output logic [CNT_W-1:0] blk_lim,
  output logic [CNT_W-1:0] thr,
  output logic             cfg_en,
  output logic [CNT_W-1:0] pending,
  output logic [CNT_W-1:0] ptr
);
  logic [REG_W-1:0] base_q, desc_q, cfg_q;
  logic [CNT_W-1:0] ring_q, prep_q, proc_q, ptr_q;
  logic [4:0]       stat_q;
  logic             cnt_clear, prep_add, add_ovf, stat_wr;
  logic [CNT_W:0]   add_pending;

  assign cnt_clear   = we && (waddr == RA_PREP || waddr == RA_PROC) && wdata[31];
  assign prep_add    = we && (waddr == RA_PREP) && !wdata[31];
  assign stat_wr     = we && (waddr == RA_STAT);
  assign pending     = prep_q - proc_q;
  assign add_pending = {1'b0, pending} + {1'b0, wdata[CNT_W-1:0]};
  assign add_ovf     = prep_add && (add_pending > {1'b0, ring_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ring_q <= '0;
      desc_q <= '0;
      cfg_q  <= '0;
    end else if (we) begin
      case (waddr)
        RA_BASE: base_q <= wdata;
        RA_RING: ring_q <= wdata[CNT_W-1:0];
        RA_DESC: desc_q <= wdata;
        RA_CFG:  cfg_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prep_q <= '0;
      proc_q <= '0;
      ptr_q  <= '0;
    end else if (cnt_clear) begin
      prep_q <= '0;
      proc_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (prep_add && !add_ovf) prep_q <= prep_q + wdata[CNT_W-1:0];
      if (done) begin
        proc_q <= proc_q + done_n;
        ptr_q  <= next_ptr(ptr_q, done_n, ring_q);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else stat_q <= (stat_q & ~(stat_wr ? wdata[4:0] : 5'd0)) | {3'd0, done, add_ovf};
  end

  always_comb begin
    case (raddr)
      RA_BASE: rdata = base_q;
      RA_RING: rdata = {16'd0, ring_q};
      RA_DESC: rdata = desc_q;
      RA_CFG:  rdata = cfg_q;
      RA_PREP: rdata = {16'd0, prep_q};
      RA_PROC: rdata = {16'd0, proc_q};
      RA_STAT: rdata = {27'd0, stat_q};
      default: rdata = {16'd0, ptr_q};
    endcase
  end

  assign ring_base = base_q;
  assign ring_size = ring_q;
  assign dlen      = desc_q[7:0];
  assign stride    = desc_q[23:16];
  assign tok       = desc_q[30];
  assign blk_lim   = cfg_q[15:0];
  assign thr       = cfg_q[31:16];
  assign cfg_en    = (cfg_q != '0);
  assign ptr       = ptr_q;

  // R3: clear hits all three counters
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> prep_q == '0 && proc_q == '0 && ptr_q == '0);
  // R4: an overflowing add leaves the count and flags it
  a_r4_ovf_refused: assert property (@(posedge clk) disable iff (!rst_n)
    add_ovf |=> prep_q == $past(prep_q) && stat_q[0]);
  // R12: processed count advances by the block on completion
  a_r12_proc_step: assert property (@(posedge clk) disable iff (!rst_n)
    done && !cnt_clear |=> proc_q == $past(proc_q) + $past(done_n));
endmodule

// File: rtl/rfm_fetch_ctl.sv
module rfm_fetch_ctl
  import rfm_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic [REG_W-1:0] ring_base,
  input  logic [CNT_W-1:0] ring_size,
  input  logic [CNT_W-1:0] blk_lim,
  input  logic [CNT_W-1:0] thr,
  input  logic [CNT_W-1:0] pending,
  input  logic [CNT_W-1:0] ptr,
  input  logic [7:0]       dlen,
  input  logic [7:0]       stride,
  input  logic             tok,
  input  logic [CW-1:0]    fifo_count,
  output logic             dma_req_valid,
  input  logic             dma_req_ready,
  output logic [REG_W-1:0] dma_req_addr,
  output logic [15:0]      dma_req_len,
  input  logic             dma_rsp_valid,
  output logic             push,
  output logic             done,
  output logic [CNT_W-1:0] done_n
);
  fetch_state_e     state_q;
  logic [CNT_W-1:0] n_q, n_now, room;
  logic [8:0]       dw_q, dw_now;
  logic [7:0]       off_q, scnt_q;
  logic [15:0]      len_q, wcnt_q;
  logic [REG_W-1:0] addr_q;
  logic [24:0]      need_words, held_words;
  logic [CW-1:0]    free_words;
  logic             issue, keep, last;

  assign dw_now     = desc_words(dlen, tok);
  assign room       = ring_size - ptr;
  assign n_now      = block_count(blk_lim, max_block(FIFO_DEPTH, dw_now), pending, room);
  assign need_words = 25'(n_now) * 25'(dw_now);
  assign held_words = 25'(n_q) * 25'(dw_q);
  assign free_words = CW'(FIFO_DEPTH) - fifo_count;
  assign issue = (state_q == FS_IDLE) && cfg_en && (pending >= thr) && (n_now != '0)
              && ({1'b0, stride} >= dw_now) && (need_words <= 25'(free_words));

  assign keep = {1'b0, scnt_q} < dw_q;
  assign last = (wcnt_q + 16'd1) == len_q;
  assign push = (state_q == FS_RESP) && dma_rsp_valid && keep;
  assign done = (state_q == FS_RESP) && dma_rsp_valid && last;
  assign done_n = n_q;

  assign dma_req_valid = (state_q == FS_REQ);
  assign dma_req_addr  = addr_q;
  assign dma_req_len   = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      n_q     <= '0;
      dw_q    <= '0;
      off_q   <= '0;
      len_q   <= '0;
      addr_q  <= '0;
      wcnt_q  <= '0;
      scnt_q  <= '0;
    end else begin
      case (state_q)
        FS_IDLE: if (issue) begin
          n_q     <= n_now;
          dw_q    <= dw_now;
          off_q   <= stride;
          len_q   <= dma_length(n_now, stride, dw_now);
          addr_q  <= fetch_addr(ring_base, ptr, stride);
          state_q <= FS_REQ;
        end
        FS_REQ: if (dma_req_ready) begin
          wcnt_q  <= '0;
          scnt_q  <= '0;
          state_q <= FS_RESP;
        end
        default: if (dma_rsp_valid) begin
          wcnt_q <= wcnt_q + 16'd1;
          scnt_q <= ({1'b0, scnt_q} + 9'd1 == {1'b0, off_q}) ? '0 : scnt_q + 8'd1;
          if (last) state_q <= FS_IDLE;
        end
      endcase
    end
  end

  // R12: a pending request keeps its fields until taken
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_valid && !dma_req_ready |=> dma_req_valid && $stable(dma_req_addr) && $stable(dma_req_len));
  // R5: a zero configuration word starts nothing
  a_r5_cfg_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !$rose(dma_req_valid));
  // R6: a new request follows a cycle with enough pending work
  a_r6_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req_valid) |-> $past(pending) >= $past(thr));
  // R11: the FIFO had room for the whole block
  a_r11_space: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req_valid) |-> held_words <= 25'(free_words));
endmodule

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch
  import rfm_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [31:0]       dma_req_addr,
  output logic [15:0]       dma_req_len,
  input  logic              dma_rsp_valid,
  input  logic [DATA_W-1:0] dma_rsp_data,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [DATA_W-1:0] desc_data
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [REG_W-1:0] ring_base;
  logic [CNT_W-1:0] ring_size, blk_lim, thr, pending, ptr, done_n;
  logic [7:0]       dlen, stride;
  logic             tok, cfg_en, done, push;
  logic [CW-1:0]    fifo_count;

  rfm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata), .done(done), .done_n(done_n),
    .ring_base(ring_base), .ring_size(ring_size), .dlen(dlen), .stride(stride), .tok(tok),
    .blk_lim(blk_lim), .thr(thr), .cfg_en(cfg_en), .pending(pending), .ptr(ptr)
  );

  rfm_fetch_ctl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .ring_base(ring_base), .ring_size(ring_size),
    .blk_lim(blk_lim), .thr(thr), .pending(pending), .ptr(ptr), .dlen(dlen), .stride(stride),
    .tok(tok), .fifo_count(fifo_count), .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_req_ready), .dma_req_addr(dma_req_addr), .dma_req_len(dma_req_len),
    .dma_rsp_valid(dma_rsp_valid), .push(push), .done(done), .done_n(done_n)
  );

  rfm_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(dma_rsp_data), .pop_ready(desc_ready),
    .out_valid(desc_valid), .out_data(desc_data), .count(fifo_count)
  );
endmodule

// File: tb/desc_ring_fetch_bench.sv
module desc_ring_fetch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic dma_req_valid, dma_req_ready = 1'b0, dma_rsp_valid = 1'b0;
  logic [31:0] dma_req_addr, dma_rsp_data = '0, desc_data;
  logic [15:0] dma_req_len;
  logic desc_valid, desc_ready = 1'b1;

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_fetch u_desc_ring_fetch (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_req_ready), .dma_req_addr(dma_req_addr), .dma_req_len(dma_req_len),
    .dma_rsp_valid(dma_rsp_valid), .dma_rsp_data(dma_rsp_data), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_data(desc_data)
  );

  always @(negedge clk) if (desc_valid && desc_ready) got_q.push_back(desc_data);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic expect_req(input logic [31:0] addr, input int n, input int dw, input int off,
                            input string tag);
    int waited = 0;
    int len = (n - 1) * off + dw;
    bit extra = 1'b0;
    while (!dma_req_valid && waited < 300) begin @(negedge clk); waited++; end
    check(dma_req_valid, {tag, " R6 request raised"}, 32'(dma_req_valid), 1);
    if (!dma_req_valid) return;
    check(dma_req_addr == addr, {tag, " R8 address"}, dma_req_addr, addr);
    check(32'(dma_req_len) == 32'(len), {tag, " R7 length"}, 32'(dma_req_len), 32'(len));
    for (int j = 0; j < n; j++)
      for (int w = 0; w < dw; w++) exp_q.push_back(addr + 32'(j * off + w));
    dma_req_ready = 1'b1;
    @(negedge clk); dma_req_ready = 1'b0;
    for (int k = 0; k < len; k++) begin
      if (k == 2) begin dma_rsp_valid = 1'b0; @(negedge clk); end
      dma_rsp_valid = 1'b1; dma_rsp_data = addr + 32'(k);
      @(negedge clk);
      if (dma_req_valid) extra = 1'b1;
    end
    dma_rsp_valid = 1'b0;
    check(!extra, {tag, " R12 one outstanding"}, 32'(extra), 0);
  endtask

  task automatic no_req(input int cyc, input string tag);
    bit seen = 1'b0;
    repeat (cyc) begin @(negedge clk); if (dma_req_valid) seen = 1'b1; end
    check(!seen, tag, 32'(seen), 0);
  endtask

  task automatic drain_compare(input string tag);
    int mism = 0;
    repeat (30) @(negedge clk);
    if (got_q.size() != exp_q.size()) mism++;
    else foreach (exp_q[i]) if (got_q[i] !== exp_q[i]) mism++;
    check(mism == 0, {tag, " R10 descriptor words"}, 32'(got_q.size()), 32'(exp_q.size()));
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog R12: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ptr, pend, proc, dw, off, mb, n, cfg_idx;
    logic [31:0] base;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), d);
      check(d == 0, "R1 register reset", d, 0);
    end
    check(!dma_req_valid && !desc_valid, "R1 outputs idle", {30'd0, dma_req_valid, desc_valid}, 0);

    // R2, R5, R3
    reg_wr(3'd1, 32'd8);
    reg_wr(3'd2, 32'h0001_0001);
    reg_wr(3'd4, 32'd3);
    reg_rd(3'd4, d); check(d == 3, "R2 prepared add", d, 3);
    reg_wr(3'd4, 32'd2);
    reg_rd(3'd4, d); check(d == 5, "R2 prepared accumulate", d, 5);
    no_req(20, "R5 zero configuration");
    reg_wr(3'd5, 32'h8000_0000);
    reg_rd(3'd4, d); check(d == 0, "R3 prepared cleared", d, 0);
    reg_rd(3'd5, d); check(d == 0, "R3 processed cleared", d, 0);

    // R4: overflow refusal and status W1C
    reg_wr(3'd1, 32'd4);
    reg_wr(3'd4, 32'd4);
    reg_rd(3'd4, d); check(d == 4, "R4 pending equal to ring accepted", d, 4);
    reg_wr(3'd4, 32'd1);
    reg_rd(3'd4, d); check(d == 4, "R4 overflowing add dropped", d, 4);
    reg_rd(3'd6, d); check(d == 1, "R4 overflow flag", d, 1);
    reg_wr(3'd6, 32'h1f);
    reg_rd(3'd6, d); check(d == 0, "R4 status write-one-clear", d, 0);
    reg_wr(3'd4, 32'h8000_0000);

    // R11: FIFO space gating (4-word descriptors, cap 3)
    desc_ready = 1'b0;
    reg_wr(3'd0, 32'h2000);
    reg_wr(3'd1, 32'd8);
    reg_wr(3'd2, 32'h0004_0004);
    reg_wr(3'd4, 32'd6);
    reg_wr(3'd3, {16'd1, 16'd3});
    expect_req(32'h2000, 3, 4, 4, "R11 first block");
    no_req(30, "R11 held back by FIFO space");
    desc_ready = 1'b1;
    expect_req(32'h200c, 3, 4, 4, "R11 second block");
    drain_compare("R11");
    reg_rd(3'd6, d); check(d == 2, "R4 block-done flag", d, 2);
    reg_wr(3'd6, 32'd2);
    reg_rd(3'd5, d); check(d == 6, "R12 processed count", d, 6);
    reg_wr(3'd3, 32'd0);

    // sweep: R7, R8, R9, R10, R6
    cfg_idx = 0;
    for (int ds = 1; ds <= 3; ds++)
      for (int tk = 0; tk <= 1; tk++)
        for (int ex = 0; ex <= 1; ex++)
          for (int fs = 1; fs <= 5; fs++)
            for (int rs = 5; rs <= 7; rs++)
              for (int th = 1; th <= 2; th++) begin
                dw = ds + tk; off = dw + ex; mb = DEPTH / dw - 1;
                base = 32'h0001_0000 + 32'(cfg_idx * 64);
                cfg_idx++;
                reg_wr(3'd3, 32'd0);
                reg_wr(3'd4, 32'h8000_0000);
                reg_wr(3'd0, base);
                reg_wr(3'd1, 32'(rs));
                reg_wr(3'd2, {1'b0, 1'(tk), 6'd0, 8'(off), 8'd0, 8'(ds)});
                ptr = 0; proc = 0; pend = rs - 1;
                reg_wr(3'd4, 32'(pend));
                reg_wr(3'd3, {16'(th), 16'(fs)});
                for (int pass = 0; pass < 2; pass++) begin
                  if (pass == 1) begin reg_wr(3'd4, 32'(rs - pend)); pend = rs; end
                  forever begin
                    n = fs;
                    if (mb < n) n = mb;
                    if (pend < n) n = pend;
                    if (rs - ptr < n) n = rs - ptr;
                    if (pend < th || n == 0) break;
                    expect_req(base + 32'(ptr * off), n, dw, off,
                               (ptr + fs > rs) ? "R9 wrap split" : "R7 block");
                    ptr = ptr + n; if (ptr == rs) ptr = 0;
                    pend -= n; proc += n;
                  end
                  no_req(12, "R6 below threshold");
                end
                drain_compare("R10 sweep");
                reg_rd(3'd5, d); check(d == 32'(proc), "R12 processed after sweep", d, 32'(proc));
                reg_rd(3'd7, d); check(d == 32'(ptr), "R9 pointer after sweep", d, 32'(ptr));
              end

    reg_wr(3'd3, 32'd0);
    reg_wr(3'd5, 32'h8000_0000);
    reg_rd(3'd7, d); check(d == 0, "R3 pointer cleared", d, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule